// File: doc/BRIEF.md
# DDR4 Command Decoder and Bank Tracker

This block samples the command and address pins of a single DDR4 device on every clock edge. It turns each sample into a command class and reports the fields that class carries: bank, row, column, auto-precharge and burst chop. It also keeps a model of all sixteen banks, recording which ones hold an open row. A violation flag is raised for any command that breaks the protocol rules listed below.

The activate pin has its own meaning here. When it is low, the row-address, column-address and write-enable pins act as high row-address bits. When it is high, those three pins select the command. Column commands are checked against two spacing rules. Commands to the same bank group need a longer gap than commands to different groups. A bank that takes a read or write stays busy for a full eight-beat burst, even when the burst is chopped to four beats.

All decode is registered. A command sampled on edge k appears on the outputs just after edge k, and the bank state is updated on that same edge. The tracker is meant to sit beside a memory controller, or in a monitor, as a protocol watchdog.

Top module: `ddr4_cmd_watch`

## Requirements
- R1: Outputs are registered, so a pin sample taken on a clock edge shows up on the outputs just after that edge. A synchronous reset clears every bank to idle and sets cmd_kind to 0 with cmd_err low.
- R2: While cs_n is high, cmd_kind is 0 (deselect) and cmd_err stays low, whatever the other pins carry. No bank is opened.
- R3: With cs_n low and act_n low, cmd_kind is 2 (activate). cmd_row takes all of addr[17:0], including the three command bits. cmd_bank is {bg,ba}, and that bank becomes open.
- R4: With act_n high, addr[16:14] select the command and cmd_kind reports the code:
  - 111 gives 1 (no-op).
  - 110 gives 9 for short calibration (addr[10]=0) or 10 for long calibration (addr[10]=1).
  - 101 gives 3 (read) and 100 gives 4 (write).
  - 011 gives 11 (reserved), and cmd_err is always raised.
  - 010 gives precharge: 5 for one bank (addr[10]=0) or 6 for all banks (addr[10]=1).
  - 001 gives 7 (refresh) and 000 gives 8 (mode-register set).
- R5: On a read or write, cmd_col = addr[9:0], cmd_ap = addr[10] and cmd_bc = addr[12]. Both flags are 0 for every other command.
- R6: A single-bank precharge closes bank {bg,ba}. An all-bank precharge closes every bank.
- R7: A read or write with auto-precharge leaves the bank open for BURST_CLK-1 edges after the command edge. The bank is then closed, so bank_open drops after edge k+BURST_CLK-1.
- R8: cmd_err is raised in each of these cases:
  - an activate to an open bank (the bank stays open);
  - a read or write to an idle bank;
  - a refresh while any bank is open.
- R9: A read or write is flagged when fewer than CCD_L edges separate it from the previous column command and both share bg. It is also flagged when fewer than CCD_S edges separate them and bg differs. A gap exactly equal to the limit is legal.
- R10: A precharge that reaches a bank within BURST_CLK-1 edges after a column command to that bank is flagged, and the bank still closes. Burst chop does not shorten this window, and other banks are unaffected. A precharge BURST_CLK edges after the command is legal.
- R11: A mode-register set is flagged when addr[17] or addr[13] is 1. It is also flagged when the register select {bg[0],ba} equals 7, since only registers 0 to 6 exist.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; pins sampled on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| act_n | input | 1 | Activate strobe, active low |
| bg | input | 2 | Bank group pins |
| ba | input | 2 | Bank address pins |
| addr | input | 18 | Address pins A17..A0; bits 16..14 double as command pins |
| cmd_kind | output | 4 | Decoded command class (codes in R2 to R4) |
| cmd_bank | output | 4 | {bg,ba} of the command, 0 on deselect |
| cmd_row | output | 18 | Row address on activate, else 0 |
| cmd_col | output | 10 | Column address on read or write, else 0 |
| cmd_ap | output | 1 | Auto-precharge requested |
| cmd_bc | output | 1 | Burst chop requested |
| cmd_err | output | 1 | Protocol violation for the command shown |
| bank_open | output | 16 | One bit per bank, set while a row is open |

## Verification
The bench probes the spacing limits one edge below and exactly at CCD_L and CCD_S. A design that compares with the wrong inequality, or picks the wrong limit from the group bits, either flags the legal gap or passes the short one.

It tracks the auto-precharge close edge by edge. A design that closes the bank one clock early or late shows a wrong bank_open bit. It also sends a precharge into a chopped burst. A design that lets burst chop shorten the busy window misses that violation, and a design that blocks other banks flags the legal precharge to a neighbour.

Activate rows that set the three command bits catch a decoder that reads those bits as a command while act_n is low. Mode-register sets with each illegal field catch incomplete checks.

// File: rtl/ddr4_cmd_watch.sv
module ddr4_cmd_watch #(
  parameter int CCD_L     = 6,
  parameter int CCD_S     = 4,
  parameter int BURST_CLK = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cs_n,
  input  logic        act_n,
  input  logic [1:0]  bg,
  input  logic [1:0]  ba,
  input  logic [17:0] addr,
  output logic [3:0]  cmd_kind,
  output logic [3:0]  cmd_bank,
  output logic [17:0] cmd_row,
  output logic [9:0]  cmd_col,
  output logic        cmd_ap,
  output logic        cmd_bc,
  output logic        cmd_err,
  output logic [15:0] bank_open
);

  localparam int GAP_W  = $clog2(CCD_L + 1);
  localparam int BUSY_W = $clog2(BURST_CLK);
  localparam logic [GAP_W-1:0]  GAP_L = GAP_W'(CCD_L);
  localparam logic [GAP_W-1:0]  GAP_S = GAP_W'(CCD_S);
  localparam logic [BUSY_W-1:0] BUSY_LD = BUSY_W'(BURST_CLK - 1);

  localparam logic [3:0] K_DES = 4'd0,  K_NOP = 4'd1,  K_ACT = 4'd2,
                         K_RD  = 4'd3,  K_WR  = 4'd4,  K_PRE = 4'd5,
                         K_PRA = 4'd6,  K_REF = 4'd7,  K_MRS = 4'd8,
                         K_ZQS = 4'd9,  K_ZQL = 4'd10, K_RSV = 4'd11;

  wire [3:0] bk = {bg, ba};

  logic [3:0] kind;
  always_comb begin
    if (cs_n)        kind = K_DES;
    else if (!act_n) kind = K_ACT;
    else begin
      case (addr[16:14])
        3'b111:  kind = K_NOP;
        3'b110:  kind = addr[10] ? K_ZQL : K_ZQS;
        3'b101:  kind = K_RD;
        3'b100:  kind = K_WR;
        3'b011:  kind = K_RSV;
        3'b010:  kind = addr[10] ? K_PRA : K_PRE;
        3'b001:  kind = K_REF;
        default: kind = K_MRS;
      endcase
    end
  end

  wire is_col = (kind == K_RD) || (kind == K_WR);

  logic [GAP_W-1:0]  gap;
  logic [1:0]        last_grp;
  logic [BUSY_W-1:0] busy [16];
  logic [15:0]       ap_pend;
  logic [15:0]       busy_vec;

  always_comb
    for (int i = 0; i < 16; i++) busy_vec[i] = (busy[i] != '0);

  wire ccd_bad = is_col && (gap < ((bg == last_grp) ? GAP_L : GAP_S));

  logic err_c;
  always_comb begin
    case (kind)
      K_ACT:      err_c = bank_open[bk];
      K_RD, K_WR: err_c = !bank_open[bk] || ccd_bad;
      K_PRE:      err_c = busy_vec[bk];
      K_PRA:      err_c = |busy_vec;
      K_REF:      err_c = |bank_open;
      K_MRS:      err_c = addr[17] || addr[13] || ({bg[0], ba} == 3'd7);
      K_RSV:      err_c = 1'b1;
      default:    err_c = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_kind <= K_DES;
      cmd_bank <= '0;
      cmd_row  <= '0;
      cmd_col  <= '0;
      cmd_ap   <= 1'b0;
      cmd_bc   <= 1'b0;
      cmd_err  <= 1'b0;
    end else begin
      cmd_kind <= kind;
      cmd_bank <= cs_n ? 4'd0 : bk;
      cmd_row  <= (kind == K_ACT) ? addr : 18'd0;
      cmd_col  <= is_col ? addr[9:0] : 10'd0;
      cmd_ap   <= is_col && addr[10];
      cmd_bc   <= is_col && addr[12];
      cmd_err  <= err_c;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gap      <= GAP_L;
      last_grp <= 2'd0;
    end else if (is_col) begin
      gap      <= GAP_W'(1);
      last_grp <= bg;
    end else if (gap < GAP_L) begin
      gap <= gap + GAP_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_open <= '0;
      ap_pend   <= '0;
      for (int i = 0; i < 16; i++) busy[i] <= '0;
    end else begin
      for (int i = 0; i < 16; i++) begin
        if (kind == K_ACT && bk == 4'(i)) begin
          bank_open[i] <= 1'b1;
        end else if ((kind == K_PRE && bk == 4'(i)) || kind == K_PRA) begin
          bank_open[i] <= 1'b0;
          ap_pend[i]   <= 1'b0;
          busy[i]      <= '0;
        end else if (is_col && bk == 4'(i) && bank_open[i]) begin
          busy[i]    <= BUSY_LD;
          ap_pend[i] <= addr[10];
        end else if (busy[i] != '0) begin
          busy[i] <= busy[i] - BUSY_W'(1);
          if (busy[i] == BUSY_W'(1) && ap_pend[i]) begin
            bank_open[i] <= 1'b0;
            ap_pend[i]   <= 1'b0;
          end
        end
      end
    end
  end

  AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> (cmd_kind == K_DES && !cmd_err)); // R2
  AST_ACT_OPENS: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !act_n) |=> (cmd_kind == K_ACT && bank_open[$past(bk)])); // R3
  AST_RSVD_FLAG: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && act_n && addr[16:14] == 3'b011) |=> (cmd_err && cmd_kind == K_RSV)); // R4
  AST_FLAGS_COL_ONLY: assert property (@(posedge clk) disable iff (rst)
    (cmd_ap || cmd_bc) |-> (cmd_kind == K_RD || cmd_kind == K_WR)); // R5
  AST_PREA_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && act_n && addr[16:14] == 3'b010 && addr[10]) |=> (bank_open == 16'd0)); // R6
  AST_REF_OPEN_FLAG: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && act_n && addr[16:14] == 3'b001 && |bank_open) |=> cmd_err); // R8

endmodule

// File: tb/ddr4_cmd_watch_test.sv
module ddr4_cmd_watch_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1, act_n = 1'b1;
  logic [1:0]  bg = '0, ba = '0;
  logic [17:0] addr = '0;
  logic [3:0]  cmd_kind, cmd_bank;
  logic [17:0] cmd_row;
  logic [9:0]  cmd_col;
  logic        cmd_ap, cmd_bc, cmd_err;
  logic [15:0] bank_open;

  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ddr4_cmd_watch uut (.clk(clk), .rst(rst), .cs_n(cs_n), .act_n(act_n), .bg(bg), .ba(ba),
    .addr(addr), .cmd_kind(cmd_kind), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
    .cmd_col(cmd_col), .cmd_ap(cmd_ap), .cmd_bc(cmd_bc), .cmd_err(cmd_err),
    .bank_open(bank_open));

  function automatic logic [17:0] ca(input logic [2:0] rcw, input logic a10, input logic a12,
                                     input logic [9:0] col);
    return {1'b0, rcw, 1'b0, a12, 1'b0, a10, col};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic c, input logic a, input logic [3:0] bank, input logic [17:0] ad);
    @(negedge clk);
    cs_n = c; act_n = a; bg = bank[3:2]; ba = bank[1:0]; addr = ad;
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) issue(1'b1, 1'b1, 4'd0, 18'd0);
  endtask

  task automatic cmd(input logic [2:0] rcw, input logic [3:0] bank, input logic a10,
                     input logic a12, input logic [9:0] col);
    issue(1'b0, 1'b1, bank, ca(rcw, a10, a12, col));
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset kind", cmd_kind, 0);
    chk("R1 reset err", cmd_err, 0);
    chk("R1 reset banks", bank_open, 0);
    @(negedge clk) rst = 1'b0;
  endtask

  task automatic t_desel;
    issue(1'b1, 1'b0, 4'd7, 18'h3FFFF);
    chk("R2 deselect kind", cmd_kind, 0);
    chk("R2 deselect err", cmd_err, 0);
    chk("R2 deselect banks", bank_open, 0);
  endtask

  task automatic t_act;
    issue(1'b0, 1'b0, 4'd5, 18'h2A5A5);
    chk("R3 act kind", cmd_kind, 2);
    chk("R3 act row", cmd_row, 18'h2A5A5);
    chk("R3 act bank", cmd_bank, 5);
    chk("R1 R3 act opens", bank_open, 16'h0020);
  endtask

  task automatic t_cmds;
    cmd(3'b111, 4'd0, 0, 0, 0); chk("R4 nop", cmd_kind, 1); chk("R4 nop err", cmd_err, 0);
    cmd(3'b110, 4'd0, 0, 0, 0); chk("R4 zq short", cmd_kind, 9);
    cmd(3'b110, 4'd0, 1, 0, 0); chk("R4 zq long", cmd_kind, 10);
    cmd(3'b011, 4'd0, 0, 0, 0); chk("R4 reserved", cmd_kind, 11); chk("R4 reserved err", cmd_err, 1);
    cmd(3'b001, 4'd0, 0, 0, 0); chk("R8 refresh kind", cmd_kind, 7); chk("R8 refresh open err", cmd_err, 1);
    cmd(3'b010, 4'd5, 0, 0, 0); chk("R6 pre kind", cmd_kind, 5); chk("R6 pre closes", bank_open, 0);
    chk("R5 pre ap flag", cmd_ap, 0);
    cmd(3'b001, 4'd0, 0, 0, 0); chk("R8 refresh idle ok", cmd_err, 0);
    cmd(3'b000, 4'd3, 0, 0, 0); chk("R11 mrs kind", cmd_kind, 8); chk("R11 mrs ok", cmd_err, 0);
    issue(1'b0, 1'b1, 4'd3, ca(3'b000, 0, 0, 0) | 18'h02000); chk("R11 mrs a13", cmd_err, 1);
    issue(1'b0, 1'b1, 4'd3, ca(3'b000, 0, 0, 0) | 18'h20000); chk("R11 mrs a17", cmd_err, 1);
    cmd(3'b000, 4'd7, 0, 0, 0); chk("R11 mrs sel7", cmd_err, 1);
  endtask

  task automatic t_rw;
    issue(1'b0, 1'b0, 4'd2, 18'h00123);
    cmd(3'b101, 4'd2, 0, 1, 10'h155);
    chk("R4 read kind", cmd_kind, 3); chk("R5 read col", cmd_col, 10'h155);
    chk("R5 read ap", cmd_ap, 0); chk("R5 read bc", cmd_bc, 1); chk("R5 read err", cmd_err, 0);
    idle(5);
    cmd(3'b100, 4'd2, 1, 0, 10'h0AA);
    chk("R4 write kind", cmd_kind, 4); chk("R5 write ap", cmd_ap, 1); chk("R5 write bc", cmd_bc, 0);
    chk("R7 write err", cmd_err, 0);
    idle(2); chk("R7 still open k+2", bank_open[2], 1);
    idle(1); chk("R7 closed k+3", bank_open[2], 0);
    idle(2);
    cmd(3'b101, 4'd2, 0, 0, 0); chk("R8 read idle bank", cmd_err, 1);
    issue(1'b0, 1'b0, 4'd5, 18'h00001); chk("R8 act idle ok", cmd_err, 0);
    issue(1'b0, 1'b0, 4'd5, 18'h00002); chk("R8 act open err", cmd_err, 1);
    chk("R8 act open stays", bank_open[5], 1);
    idle(6);
    cmd(3'b010, 4'd0, 1, 0, 0); chk("R6 prea kind", cmd_kind, 6);
    chk("R6 prea closes", bank_open, 0); chk("R6 prea err", cmd_err, 0);
  endtask

  task automatic t_ccd;
    issue(1'b0, 1'b0, 4'd0, 18'h10); issue(1'b0, 1'b0, 4'd1, 18'h11); issue(1'b0, 1'b0, 4'd4, 18'h12);
    cmd(3'b101, 4'd0, 0, 0, 0); chk("R9 first read", cmd_err, 0);
    idle(4); cmd(3'b101, 4'd1, 0, 0, 0); chk("R9 same group gap5", cmd_err, 1);
    idle(5); cmd(3'b101, 4'd1, 0, 0, 0); chk("R9 same group gap6", cmd_err, 0);
    idle(3); cmd(3'b101, 4'd4, 0, 0, 0); chk("R9 other group gap4", cmd_err, 0);
    idle(2); cmd(3'b101, 4'd0, 0, 0, 0); chk("R9 other group gap3", cmd_err, 1);
    idle(3); cmd(3'b010, 4'd0, 1, 0, 0); chk("R10 prea after window", cmd_err, 0);
  endtask

  task automatic t_busy;
    issue(1'b0, 1'b0, 4'd8, 18'h20); issue(1'b0, 1'b0, 4'd12, 18'h21); issue(1'b0, 1'b0, 4'd9, 18'h22);
    idle(6);
    cmd(3'b101, 4'd8, 0, 1, 0); chk("R10 chopped read", cmd_err, 0);
    cmd(3'b010, 4'd12, 0, 0, 0); chk("R10 other bank pre ok", cmd_err, 0);
    chk("R10 other bank closed", bank_open[12], 0);
    cmd(3'b010, 4'd8, 0, 0, 0); chk("R10 pre in chopped burst", cmd_err, 1);
    chk("R10 busy bank closes", bank_open[8], 0);
    idle(3);
    cmd(3'b101, 4'd9, 0, 0, 0); chk("R10 read bank9", cmd_err, 0);
    idle(3);
    cmd(3'b010, 4'd9, 0, 0, 0); chk("R10 pre at window end", cmd_err, 0);
    chk("R10 bank9 closed", bank_open[9], 0);
  endtask

  initial begin
    t_reset();
    t_desel();
    t_act();
    t_cmds();
    t_rw();
    t_ccd();
    t_busy();
    idle(1);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule